// File: doc/BRIEF.md
# Circular Receive Buffer Writer

This block takes received frame bytes from a byte stream, one byte per cycle, with first-byte and last-byte markers. It packs the bytes into 16-bit words and writes them through a single-port SRAM write interface into a ring-shaped receive area. The area starts at a configurable start address and ends at a fixed top byte address, 16'h5FFF by default. Every frame starts on an even byte address. After an odd-length frame the write position skips the unused upper byte of its last word.

The block polices frame length against a programmable limit. An override switch accepts frames of any size. The host supplies a fence address that marks data not yet consumed. The block discards a frame that would write the word holding that address. A discarded frame gives back all of its space: the next frame starts where the discarded one started. One cycle after each last byte, the block reports either the start address and byte count of the accepted frame, or a drop with its cause.

Top module: `rx_ring_writer`

## Requirements
- R1: Words are written only at word addresses from the start word up to the top word (16'h5FFF >> 1). After the byte at 16'h5FFF the next byte goes to the start address.
- R2: Bit 0 of `cfg_start` is ignored. A start of 16'h5FE1 places the first frame at 16'h5FE0.
- R3: The first frame after reset starts at the start address. Every frame starts at an even address. After an odd-length frame, the next frame starts at the following even address.
- R4: Byte pairs are packed with the earlier byte in bits 7:0 and the later byte in bits 15:8. The final byte of an odd-length frame is written with bits 15:8 zero. `ram_addr` is the byte address shifted right by one. The write appears on the cycle after the pair's second byte, or after the last byte.
- R5: With `cfg_any_len` = 0, a frame longer than `cfg_max_len` bytes is dropped (`drop_valid` = 1, `drop_overflow` = 0). Bytes beyond the limit are not written. A frame of exactly `cfg_max_len` bytes is accepted.
- R6: With `cfg_any_len` = 1, no length limit applies.
- R7: After a dropped frame, the next frame starts at the dropped frame's start address.
- R8: The word holding `host_fence` is never written. A frame that reaches that word on the first byte of a pair is dropped with `drop_overflow` = 1.
- R9: One cycle after a last byte, exactly one of `done_valid` or `drop_valid` is high, for one cycle. `done_start` gives the frame's start byte address and `done_len` gives its byte count.
- R10: After reset, `ram_we`, `done_valid` and `drop_valid` are 0.
- R11: A byte with `in_valid` set, outside any frame and without `in_sof`, is ignored. It causes no write and no report, and it does not move the write position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; samples `cfg_start` |
| cfg_start | input | 16 | Ring start byte address (bit 0 ignored) |
| cfg_max_len | input | 16 | Largest accepted frame length in bytes |
| cfg_any_len | input | 1 | 1 = no length limit |
| host_fence | input | 16 | Byte address whose word must not be overwritten |
| in_valid | input | 1 | Byte present this cycle |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_byte | input | 8 | Received byte |
| ram_we | output | 1 | SRAM word write enable |
| ram_addr | output | 15 | SRAM word address |
| ram_wdata | output | 16 | SRAM write data |
| done_valid | output | 1 | Accepted-frame report, one cycle |
| done_start | output | 16 | Start byte address of the accepted frame |
| done_len | output | 16 | Byte count of the accepted frame |
| drop_valid | output | 1 | Dropped-frame report, one cycle |
| drop_overflow | output | 1 | Drop cause: 1 = fence overrun, 0 = too long |

## Verification
Checks that run on every cycle cover the following: writes stay inside the ring and never touch the fence word, an accepted length never exceeds the limit while the limit is active, completion and drop are never reported together, and the commit point holds still when a frame is dropped. Only the bench scenarios can show the rest. These include the exact packing of bytes into words, the start address of each frame after padding, wraparound and rollback, the treatment of stray bytes outside a frame, and whether the limit switch and the fence take effect on the right byte.

// File: rtl/rxw_pkg.sv
package rxw_pkg;
  typedef enum logic {
    CAUSE_LENGTH   = 1'b0,
    CAUSE_OVERFLOW = 1'b1
  } drop_cause_e;
endpackage

// File: rtl/rxw_wrap_step.sv
module rxw_wrap_step #(
  parameter int WA_W = 15,
  parameter logic [WA_W-1:0] TOP_WORD = 15'h2FFF
) (
  input  logic [WA_W-1:0] cur,
  input  logic [WA_W-1:0] base,
  output logic [WA_W-1:0] nxt
);
  always_comb begin
    if (cur == TOP_WORD) nxt = base;
    else                 nxt = cur + 1'b1;
  end
endmodule

// File: rtl/rxw_len_guard.sv
module rxw_len_guard #(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0] len_in,
  input  logic [LEN_W-1:0] limit,
  input  logic             no_limit,
  output logic [LEN_W-1:0] len_out,
  output logic             over
);
  always_comb begin
    if (len_in == {LEN_W{1'b1}}) len_out = len_in;
    else                         len_out = len_in + 1'b1;
    over = !no_limit && (len_out > limit);
  end
endmodule

// File: rtl/rxw_word_port.sv
module rxw_word_port #(
  parameter int WA_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_d,
  input  logic [WA_W-1:0] addr_d,
  input  logic [15:0]     data_d,
  output logic            we_q,
  output logic [WA_W-1:0] addr_q,
  output logic [15:0]     data_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      we_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      we_q <= we_d;
      if (we_d) begin
        addr_q <= addr_d;
        data_q <= data_d;
      end
    end
  end
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxw_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] TOP_ADDR = 16'h5FFF,
  parameter int LEN_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_any_len,
  input  logic [ADDR_W-1:0] host_fence,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic              in_eof,
  input  logic [7:0]        in_byte,
  output logic              ram_we,
  output logic [ADDR_W-2:0] ram_addr,
  output logic [15:0]       ram_wdata,
  output logic              done_valid,
  output logic [ADDR_W-1:0] done_start,
  output logic [LEN_W-1:0]  done_len,
  output logic              drop_valid,
  output logic              drop_overflow
);
  localparam int WA_W = ADDR_W - 1;
  localparam logic [WA_W-1:0] TOP_WORD = TOP_ADDR[ADDR_W-1:1];

  // frame state
  logic [WA_W-1:0]  start_w;   // ring base word, captured at reset
  logic [WA_W-1:0]  commit_w;  // word where the next frame begins
  logic [WA_W-1:0]  wr_w;      // word being filled
  logic             in_frame;
  logic             odd_phase; // 1: low byte already held
  logic [7:0]       low_byte;
  logic [LEN_W-1:0] cnt;
  logic             bad;
  drop_cause_e      cause;

  // effective values for the byte in flight (a first byte restarts)
  logic             take;
  logic [WA_W-1:0]  f_w;
  logic             f_phase;
  logic [LEN_W-1:0] f_cnt;
  logic             f_bad;
  drop_cause_e      f_cause;
  logic [WA_W-1:0]  step_w;
  logic [LEN_W-1:0] cnt_new;
  logic             too_long;
  logic             fence_hit;
  logic             n_bad;
  drop_cause_e      n_cause;
  logic             wr_en;
  logic [15:0]      wr_data;

  always_comb begin
    take    = in_valid && (in_sof || in_frame);
    f_w     = in_sof ? commit_w : wr_w;
    f_phase = in_sof ? 1'b0 : odd_phase;
    f_cnt   = in_sof ? '0 : cnt;
    f_bad   = in_sof ? 1'b0 : bad;
    f_cause = in_sof ? CAUSE_LENGTH : cause;
  end

  rxw_wrap_step #(.WA_W(WA_W), .TOP_WORD(TOP_WORD)) u_step (
    .cur (f_w),
    .base(start_w),
    .nxt (step_w)
  );

  rxw_len_guard #(.LEN_W(LEN_W)) u_len (
    .len_in  (f_cnt),
    .limit   (cfg_max_len),
    .no_limit(cfg_any_len),
    .len_out (cnt_new),
    .over    (too_long)
  );

  always_comb begin
    fence_hit = !f_phase && (f_w == host_fence[ADDR_W-1:1]);
    n_bad     = f_bad || too_long || fence_hit;
    if (f_bad)         n_cause = f_cause;
    else if (too_long) n_cause = CAUSE_LENGTH;
    else               n_cause = CAUSE_OVERFLOW;
    wr_en     = take && !n_bad && (f_phase || in_eof);
    wr_data   = f_phase ? {in_byte, low_byte} : {8'h00, in_byte};
  end

  rxw_word_port #(.WA_W(WA_W)) u_port (
    .clk   (clk),
    .rst   (rst),
    .we_d  (wr_en),
    .addr_d(f_w),
    .data_d(wr_data),
    .we_q  (ram_we),
    .addr_q(ram_addr),
    .data_q(ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_w       <= cfg_start[ADDR_W-1:1];
      commit_w      <= cfg_start[ADDR_W-1:1];
      wr_w          <= cfg_start[ADDR_W-1:1];
      in_frame      <= 1'b0;
      odd_phase     <= 1'b0;
      low_byte      <= '0;
      cnt           <= '0;
      bad           <= 1'b0;
      cause         <= CAUSE_LENGTH;
      done_valid    <= 1'b0;
      done_start    <= '0;
      done_len      <= '0;
      drop_valid    <= 1'b0;
      drop_overflow <= 1'b0;
    end else begin
      done_valid <= 1'b0;
      drop_valid <= 1'b0;
      if (take) begin
        cnt   <= cnt_new;
        bad   <= n_bad;
        cause <= n_cause;
        if (in_eof) begin
          in_frame  <= 1'b0;
          odd_phase <= 1'b0;
          if (!n_bad) begin
            commit_w   <= step_w;   // pads an odd tail to the next word
            done_valid <= 1'b1;
            done_start <= {commit_w, 1'b0};
            done_len   <= cnt_new;
          end else begin
            drop_valid    <= 1'b1;  // commit_w kept: space is rolled back
            drop_overflow <= (n_cause == CAUSE_OVERFLOW);
          end
        end else begin
          in_frame  <= 1'b1;
          odd_phase <= !f_phase;
          wr_w      <= f_phase ? step_w : f_w;
          if (!f_phase) low_byte <= in_byte;
        end
      end
    end
  end

  AST_IN_RING: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr >= start_w && ram_addr <= TOP_WORD)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_addr != $past(host_fence[ADDR_W-1:1]))); // R8
  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> ($past(cfg_any_len) || done_len <= $past(cfg_max_len))); // R5
  AST_ONE_REPORT: assert property (@(posedge clk) disable iff (rst)
    !(done_valid && drop_valid)); // R9
  AST_ROLLBACK: assert property (@(posedge clk) disable iff (rst)
    drop_valid |-> $stable(commit_w)); // R7
endmodule

// File: tb/rx_ring_writer_test.sv
module rx_ring_writer_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [15:0] cfg_start, cfg_max_len, host_fence;
  logic        cfg_any_len;
  logic        in_valid, in_sof, in_eof;
  logic [7:0]  in_byte;
  logic        ram_we;
  logic [14:0] ram_addr;
  logic [15:0] ram_wdata;
  logic        done_valid, drop_valid, drop_overflow;
  logic [15:0] done_start, done_len;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  rx_ring_writer uut (
    .clk(clk), .rst(rst), .cfg_start(cfg_start), .cfg_max_len(cfg_max_len),
    .cfg_any_len(cfg_any_len), .host_fence(host_fence), .in_valid(in_valid),
    .in_sof(in_sof), .in_eof(in_eof), .in_byte(in_byte), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .done_valid(done_valid),
    .done_start(done_start), .done_len(done_len), .drop_valid(drop_valid),
    .drop_overflow(drop_overflow)
  );

  // {len[15:0], good_bytes[15:0], expected_start[15:0], drop}
  // ring 5FE0..5FFF, limit 12, fence outside the ring
  localparam logic [48:0] VEC [6] = '{
    {16'd5,  16'd5,  16'h5FE0, 1'b0},  // R3 R4 odd length
    {16'd4,  16'd4,  16'h5FE6, 1'b0},  // R3 padded start
    {16'd13, 16'd12, 16'h5FEA, 1'b1},  // R5 too long
    {16'd12, 16'd12, 16'h5FEA, 1'b0},  // R7 R5 exact limit
    {16'd12, 16'd12, 16'h5FF6, 1'b0},  // R1 wraps past top
    {16'd1,  16'd1,  16'h5FE2, 1'b0}   // R1 R4 after wrap
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] next_byte(input logic [15:0] a, input logic [15:0] base);
    return (a == 16'h5FFF) ? {base[15:1], 1'b0} : a + 16'd1;
  endfunction

  task automatic do_reset(input logic [15:0] st, input logic [15:0] fence,
                          input logic [15:0] maxl, input bit any);
    cfg_start = st; host_fence = fence; cfg_max_len = maxl; cfg_any_len = any;
    in_valid = 0; in_sof = 0; in_eof = 0; in_byte = 0;
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic send_frame(input int len, input int good, input logic [7:0] seed,
                            input logic [15:0] exp_start, input bit exp_drop,
                            input bit exp_ovf, input string req);
    logic [15:0] ea;
    logic [14:0] pair_w;
    logic [7:0]  prev;
    logic [15:0] wexp;
    int werr;
    logic [31:0] first_act, first_exp;
    ea = exp_start; pair_w = '0; prev = '0; wexp = '0; werr = 0;
    first_act = '0; first_exp = '0;
    for (int i = 1; i <= len; i++) begin
      logic [7:0] b;
      bit expect_we;
      b = seed + 8'(i);
      in_valid = 1; in_sof = (i == 1); in_eof = (i == len); in_byte = b;
      if (i % 2 == 1) pair_w = ea[15:1];
      @(negedge clk);
      expect_we = (i <= good) && ((i % 2 == 0) || (i == len));
      wexp = (i % 2 == 0) ? {b, prev} : {8'h00, b};
      if (ram_we !== expect_we ||
          (expect_we && (ram_addr !== pair_w || ram_wdata !== wexp))) begin
        if (werr == 0) begin
          first_act = {ram_we, ram_addr, ram_wdata};
          first_exp = {expect_we, pair_w, wexp};
        end
        werr++;
      end
      prev = b;
      ea = next_byte(ea, cfg_start);
    end
    in_valid = 0; in_sof = 0; in_eof = 0;
    check(werr == 0, req, "word writes {we,addr,data}", first_act, first_exp);
    if (exp_drop)
      check(drop_valid && !done_valid && drop_overflow == exp_ovf, req,
            "drop report {drop,done,ovf}", {drop_valid, done_valid, drop_overflow},
            {1'b1, 1'b0, exp_ovf});
    else
      check(done_valid && !drop_valid && done_start == exp_start && done_len == 16'(len),
            req, "done report {valid,start,len}", {done_valid, done_start[14:0], done_len},
            {1'b1, exp_start[14:0], 16'(len)});
    @(negedge clk);
    check(!done_valid && !drop_valid, "R9", "report lasts one cycle",
          {done_valid, drop_valid}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(16'h5FE0, 16'h5FDE, 16'd12, 1'b0);
    check(!ram_we && !done_valid && !drop_valid, "R10", "outputs after reset",
          {ram_we, done_valid, drop_valid}, 0);

    for (int k = 0; k < 6; k++) begin
      send_frame(int'(VEC[k][48:33]), int'(VEC[k][32:17]), 8'(k * 16),
                 VEC[k][16:1], VEC[k][0], 1'b0, "R1 R3 R4 R5 R7 R9 table");
    end

    // R11: stray bytes outside a frame leave everything untouched
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 3; i++) begin
        in_valid = 1; in_sof = 0; in_eof = (i == 2); in_byte = 8'hA0 + 8'(i);
        @(negedge clk);
        if (ram_we || done_valid || drop_valid) seen++;
      end
      in_valid = 0; in_eof = 0;
      @(negedge clk);
      if (ram_we || done_valid || drop_valid) seen++;
      check(seen == 0, "R11", "stray bytes caused activity", seen, 0);
    end
    send_frame(2, 2, 8'h40, 16'h5FE4, 1'b0, 1'b0, "R11 position unchanged");

    // R6: limit switched off
    do_reset(16'h5FE0, 16'h5FDE, 16'd12, 1'b1);
    send_frame(20, 20, 8'h10, 16'h5FE0, 1'b0, 1'b0, "R6 any length");

    // R2: odd start pointer
    do_reset(16'h5FE1, 16'h5FDE, 16'd12, 1'b0);
    send_frame(3, 3, 8'h20, 16'h5FE0, 1'b0, 1'b0, "R2 R3 odd start");

    // R8: fence overrun, then R7 rollback
    do_reset(16'h5FE0, 16'h5FE8, 16'd12, 1'b0);
    send_frame(6, 6, 8'h30, 16'h5FE0, 1'b0, 1'b0, "R8 below fence");
    send_frame(6, 2, 8'h50, 16'h5FE6, 1'b1, 1'b1, "R8 fence overrun");
    host_fence = 16'h5FDE;
    send_frame(2, 2, 8'h60, 16'h5FE6, 1'b0, 1'b0, "R7 rollback after overrun");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule